// File: doc/BRIEF.md
# Power-Management Register File with Interrupt Controller

This block is the register side of a power-management companion chip. A host reaches it through a simple register port: a write strobe, a 5-bit register index, 16-bit write data, and 16-bit read data that follows the index combinationally. Behind that port sit an interrupt controller, a readout window onto a bank of ADC conversion results, two general control registers, a calibration register, a sample-flag register, a status register that tracks the power key, and a watchdog that can ask the system to shut down.

Interrupt status bits are raised by hardware events: a power-key edge and the selection of an ADC channel. Software clears them by writing ones to the status register, which toggles them. The mask is active-high, so a 1 in the mask disables that source. The single interrupt line is high whenever an unmasked status bit is set. ADC values come in as a flat vector of per-channel results. Conversion itself and any real-time counting happen outside this block.

Top module: `pmic_regfile`

## Requirements
- R1: `irq` is high exactly when some interrupt status bit is 1 while the mask bit at the same position is 0. After reset the mask is 0xFFFF, the status is 0x0000, and `irq` is low.
- R2: A write to index 0x01 XORs the written value into the interrupt status. A read of index 0x01 returns the status unmasked.
- R3: Index 0x02 is the interrupt mask. It can be read and written.
- R4: Index 0x00 reads 0x0215, with bit 7 also set when parameter `VARIANT` is 1. Writes to it have no effect.
- R5: A write to index 0x08 selects the ADC channel given by write-data bits 13:10 and sets interrupt status bit 8 on the same clock edge. A read of index 0x08 returns the selected channel in bits 13:10 OR'd with that channel's 10-bit result, where channel c occupies `adc_data[c*10 +: 10]`.
- R6: Index 0x09 holds sample flags. Each 1 in a write clears that flag, and each `sample_set` bit sets its flag. When both act on a flag in the same cycle, the set wins.
- R7: Indices 0x0D and 0x0E are read/write control registers that reset to 0. Index 0x06 is a read/write calibration register that resets to 0x0001.
- R8: A write of 0x0000 to index 0x17 while bit 1 of index 0x0D is set makes `shutdown_req` high for exactly the following cycle. Any other value, or that bit being clear, gives no pulse.
- R9: Index 0x16 is read-only and resets to 0x0020. A `key_event` pulse sets interrupt status bit 0 and makes status bit 5 equal to the inverse of `key_down`.
- R10: Every other index reads 0x0000, and writes to it have no effect.
- R11: When a hardware event and a software XOR write hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_wr | input | 1 | Register write strobe |
| acc_idx | input | 5 | Register index for reads and writes |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data for `acc_idx` (combinational) |
| key_event | input | 1 | One-cycle pulse on a power-key change |
| key_down | input | 1 | Power-key level, 1 = pressed |
| sample_set | input | 16 | Per-bit set pulses for the sample flags |
| adc_data | input | 160 | Sixteen 10-bit conversion results |
| irq | output | 1 | Interrupt request |
| shutdown_req | output | 1 | One-cycle shutdown request |

## Verification
The assertions check these rules on every cycle:
- An ADC-select write or a key event always leaves its status bit set (R5, R9, R11).
- A full mask silences `irq` (R1).
- A shutdown pulse only follows a zero write to the watchdog index and never lasts two cycles (R8).
- The ID read is constant (R4).

Other behaviour needs the bench's stored-state scenarios:
- The XOR clearing of status bits (R2).
- The per-channel readout across all sixteen channels (R5).
- The write-one-to-clear flags (R6).
- The control-bit gating of shutdown (R8).
- The zero reads and ignored writes on unused indices (R10).

// File: rtl/pmic_regfile.sv
module pmic_regfile #(
  parameter bit          VARIANT     = 1'b0,
  parameter logic [15:0] ID_BASE     = 16'h0215,
  parameter logic [15:0] CAL_RESET   = 16'h0001,
  parameter logic [15:0] STAT_RESET  = 16'h0020,
  parameter int          NUM_CH      = 16,
  parameter int          RES_W       = 10,
  parameter int          CH_LSB      = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_wr,
  input  logic [4:0]              acc_idx,
  input  logic [15:0]             acc_wdata,
  output logic [15:0]             acc_rdata,
  input  logic                    key_event,
  input  logic                    key_down,
  input  logic [15:0]             sample_set,
  input  logic [NUM_CH*RES_W-1:0] adc_data,
  output logic                    irq,
  output logic                    shutdown_req
);
  localparam int CH_W = $clog2(NUM_CH);
  localparam logic [4:0] IX_ID    = 5'h00;
  localparam logic [4:0] IX_IST   = 5'h01;
  localparam logic [4:0] IX_MASK  = 5'h02;
  localparam logic [4:0] IX_CAL   = 5'h06;
  localparam logic [4:0] IX_ADC   = 5'h08;
  localparam logic [4:0] IX_SMP   = 5'h09;
  localparam logic [4:0] IX_CTL1  = 5'h0D;
  localparam logic [4:0] IX_CTL2  = 5'h0E;
  localparam logic [4:0] IX_STAT  = 5'h16;
  localparam logic [4:0] IX_WDOG  = 5'h17;
  localparam int BIT_KEY  = 0;
  localparam int BIT_ADC  = 8;
  localparam int BIT_KLVL = 5;
  localparam int SHUT_EN  = 1;
  localparam logic [15:0] ID_VAL = ID_BASE | (VARIANT ? 16'h0080 : 16'h0000);

  logic [15:0]     irq_st, irq_mask, cal, smp, ctl1, ctl2, stat;
  logic [CH_W-1:0] adc_ch;
  logic [RES_W-1:0] adc_res;
  logic [15:0]     hw_set, sw_xor;

  wire wr_ist  = acc_wr && acc_idx == IX_IST;
  wire wr_adc  = acc_wr && acc_idx == IX_ADC;
  wire wr_smp  = acc_wr && acc_idx == IX_SMP;
  wire wr_wdog = acc_wr && acc_idx == IX_WDOG;

  assign adc_res = adc_data[adc_ch*RES_W +: RES_W];
  assign sw_xor  = wr_ist ? acc_wdata : 16'h0000;

  always_comb begin
    hw_set = '0;
    hw_set[BIT_KEY] = key_event;
    hw_set[BIT_ADC] = wr_adc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_st       <= '0;
      irq_mask     <= 16'hFFFF;
      cal          <= CAL_RESET;
      smp          <= '0;
      ctl1         <= '0;
      ctl2         <= '0;
      stat         <= STAT_RESET;
      adc_ch       <= '0;
      shutdown_req <= 1'b0;
    end else begin
      irq_st       <= (irq_st ^ sw_xor) | hw_set;
      smp          <= (smp & ~(wr_smp ? acc_wdata : 16'h0000)) | sample_set;
      shutdown_req <= wr_wdog && acc_wdata == 16'h0000 && ctl1[SHUT_EN];
      if (key_event) stat[BIT_KLVL] <= ~key_down;
      if (wr_adc) adc_ch <= acc_wdata[CH_LSB +: CH_W];
      if (acc_wr) begin
        case (acc_idx)
          IX_MASK: irq_mask <= acc_wdata;
          IX_CAL:  cal      <= acc_wdata;
          IX_CTL1: ctl1     <= acc_wdata;
          IX_CTL2: ctl2     <= acc_wdata;
          default: ;
        endcase
      end
    end
  end

  assign irq = |(irq_st & ~irq_mask);

  always_comb begin
    acc_rdata = '0;
    case (acc_idx)
      IX_ID:   acc_rdata = ID_VAL;
      IX_IST:  acc_rdata = irq_st;
      IX_MASK: acc_rdata = irq_mask;
      IX_CAL:  acc_rdata = cal;
      IX_ADC: begin
        acc_rdata[CH_LSB +: CH_W] = adc_ch;
        acc_rdata[RES_W-1:0]      = adc_res;
      end
      IX_SMP:  acc_rdata = smp;
      IX_CTL1: acc_rdata = ctl1;
      IX_CTL2: acc_rdata = ctl2;
      IX_STAT: acc_rdata = stat;
      default: acc_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pmic_regfile_chk.sv
module pmic_regfile_chk #(
  parameter logic [15:0] ID_VAL = 16'h0215
) (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_wr,
  input logic [4:0]  acc_idx,
  input logic [15:0] acc_wdata,
  input logic [15:0] acc_rdata,
  input logic        key_event,
  input logic        irq,
  input logic        shutdown_req,
  input logic [15:0] irq_st
);
  AST_MASK_ALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && acc_idx == 5'h02 && acc_wdata == 16'hFFFF) |=> !irq); // R1
  AST_ID_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_idx == 5'h00) |-> (acc_rdata == ID_VAL)); // R4
  AST_ADC_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && acc_idx == 5'h08) |=> irq_st[8]); // R5
  AST_SHUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> !shutdown_req); // R8
  AST_SHUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutdown_req) |-> $past(acc_wr && acc_idx == 5'h17 && acc_wdata == 16'h0000)); // R8
  AST_KEY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    key_event |=> irq_st[0]); // R9 R11
endmodule

bind pmic_regfile pmic_regfile_chk #(.ID_VAL(ID_VAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_idx(acc_idx),
  .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .key_event(key_event),
  .irq(irq), .shutdown_req(shutdown_req), .irq_st(irq_st)
);

// File: tb/pmic_regfile_tb.sv
`timescale 1ns/1ps
module pmic_regfile_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         acc_wr = 1'b0;
  logic [4:0]   acc_idx = '0;
  logic [15:0]  acc_wdata = '0;
  logic [15:0]  acc_rdata;
  logic         key_event = 1'b0;
  logic         key_down = 1'b0;
  logic [15:0]  sample_set = '0;
  logic [159:0] adc_data;
  logic         irq, shutdown_req;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_st = 16'h0000;
  logic [15:0] m_mask = 16'hFFFF;

  always #10 clk = ~clk;

  pmic_regfile #(.VARIANT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_idx(acc_idx),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .key_event(key_event),
    .key_down(key_down), .sample_set(sample_set), .adc_data(adc_data),
    .irq(irq), .shutdown_req(shutdown_req)
  );

  function automatic logic [9:0] res_of(int c);
    return 10'((c * 67 + 5) % 1024);
  endfunction

  always_comb
    for (int c = 0; c < 16; c++) adc_data[c*10 +: 10] = res_of(c);

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] idx, logic [15:0] d);
    @(negedge clk);
    acc_wr = 1'b1; acc_idx = idx; acc_wdata = d;
    @(negedge clk);
    acc_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] idx, output logic [15:0] d);
    acc_idx = idx;
    #1 d = acc_rdata;
  endtask

  task automatic set_st(logic [15:0] want);
    wr(5'h01, m_st ^ want);
    m_st = want;
  endtask

  initial begin
    for (int k = 0; k < 20000; k++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset values over all indices
    for (int i = 0; i < 32; i++) begin
      logic [15:0] e;
      case (i)
        'h00: e = 16'h0295;
        'h02: e = 16'hFFFF;
        'h06: e = 16'h0001;
        'h08: e = {6'd0, res_of(0)};
        'h16: e = 16'h0020;
        default: e = 16'h0000;
      endcase
      rd(5'(i), d); chk("R4 R7 R9 reset read", d, e);
    end
    chk("R1 reset irq", {15'd0, irq}, 16'h0000);
    chk("R8 reset shutdown", {15'd0, shutdown_req}, 16'h0000);

    // R3 mask read/write
    wr(5'h02, 16'h5A3C); m_mask = 16'h5A3C;
    rd(5'h02, d); chk("R3 mask rw", d, 16'h5A3C);

    // R1/R2 sweep: one unmasked bit, status on it or on its neighbour
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 2; j++) begin
        logic [15:0] s;
        s = 16'(1 << ((i + j) % 16));
        wr(5'h02, ~16'(1 << i)); m_mask = ~16'(1 << i);
        set_st(s);
        rd(5'h01, d); chk("R2 raw status", d, s);
        chk("R1 irq vs mask", {15'd0, irq}, {15'd0, |(m_st & ~m_mask)});
      end
    end
    set_st(16'hA5C3);
    rd(5'h01, d); chk("R2 xor toggle", d, 16'hA5C3);
    set_st(16'h0000);
    wr(5'h02, 16'h0000); m_mask = 16'h0000;
    chk("R1 irq idle", {15'd0, irq}, 16'h0000);

    // R5 channel sweep
    for (int c = 0; c < 16; c++) begin
      wr(5'h08, 16'(c << 10) | 16'h83FF);
      m_st[8] = 1'b1;
      rd(5'h08, d); chk("R5 adc read", d, 16'(c << 10) | {6'd0, res_of(c)});
      rd(5'h01, d); chk("R5 adc done bit", d, m_st);
      chk("R5 adc irq", {15'd0, irq}, 16'h0001);
      set_st(16'h0000);
    end

    // R6 sample flags
    @(negedge clk); sample_set = 16'hF0F0;
    @(negedge clk); sample_set = 16'h0000;
    rd(5'h09, d); chk("R6 set flags", d, 16'hF0F0);
    wr(5'h09, 16'h3030);
    rd(5'h09, d); chk("R6 w1c", d, 16'hC0C0);
    @(negedge clk);
    acc_wr = 1'b1; acc_idx = 5'h09; acc_wdata = 16'hFFFF; sample_set = 16'h0101;
    @(negedge clk);
    acc_wr = 1'b0; sample_set = 16'h0000;
    rd(5'h09, d); chk("R6 set beats clear", d, 16'h0101);

    // R7 control and calibration
    wr(5'h0D, 16'h1234); wr(5'h0E, 16'hFEDC); wr(5'h06, 16'h0BEE);
    rd(5'h0D, d); chk("R7 ctl1", d, 16'h1234);
    rd(5'h0E, d); chk("R7 ctl2", d, 16'hFEDC);
    rd(5'h06, d); chk("R7 cal", d, 16'h0BEE);

    // R8 watchdog
    wr(5'h0D, 16'h0000);
    wr(5'h17, 16'h0000);
    chk("R8 no pulse when disabled", {15'd0, shutdown_req}, 16'h0000);
    wr(5'h0D, 16'h0002);
    wr(5'h17, 16'h0005);
    chk("R8 no pulse nonzero", {15'd0, shutdown_req}, 16'h0000);
    wr(5'h17, 16'h0000);
    chk("R8 pulse", {15'd0, shutdown_req}, 16'h0001);
    @(negedge clk);
    chk("R8 pulse ends", {15'd0, shutdown_req}, 16'h0000);

    // R9 power key
    @(negedge clk); key_event = 1'b1; key_down = 1'b1;
    @(negedge clk); key_event = 1'b0;
    m_st[0] = 1'b1;
    rd(5'h16, d); chk("R9 pressed", d, 16'h0000);
    rd(5'h01, d); chk("R9 key irq bit", d, m_st);
    @(negedge clk); key_down = 1'b0;
    rd(5'h16, d); chk("R9 level alone no effect", d, 16'h0000);
    @(negedge clk); key_event = 1'b1;
    @(negedge clk); key_event = 1'b0;
    rd(5'h16, d); chk("R9 released", d, 16'h0020);

    // R11 hardware set beats same-cycle xor
    @(negedge clk);
    acc_wr = 1'b1; acc_idx = 5'h01; acc_wdata = 16'h0001; key_event = 1'b1;
    @(negedge clk);
    acc_wr = 1'b0; key_event = 1'b0;
    rd(5'h01, d); chk("R11 merge", d, 16'h0001);

    // R4 / R9 read-only, R10 unused indices
    wr(5'h00, 16'hFFFF); rd(5'h00, d); chk("R4 id write ignored", d, 16'h0295);
    wr(5'h16, 16'h0000); rd(5'h16, d); chk("R9 status write ignored", d, 16'h0020);
    for (int i = 0; i < 32; i++) begin
      if (!(i inside {'h00, 'h01, 'h02, 'h06, 'h08, 'h09, 'h0D, 'h0E, 'h16, 'h17})) begin
        wr(5'(i), 16'hFFFF);
        rd(5'(i), d); chk("R10 unused reads zero", d, 16'h0000);
      end
    end
    rd(5'h0D, d); chk("R10 neighbours untouched", d, 16'h0002);
    rd(5'h01, d); chk("R10 status untouched", d, 16'h0001);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule